// File: doc/BRIEF.md
# Three-Channel Serial Register Front End

This block is the software-visible register layer in front of three serial channels. A simple request port carries one access per cycle: a byte offset, a direction and a width flag that marks the access as one byte or two bytes. Each channel has a 16-bit control word, an 8-bit interrupt-mode byte, a transmit byte, a receive byte and a status word. Channel 2 also has an 8-bit timer byte. The block decodes the offset and checks the access width against the target register. It also checks the direction and any bits that software may not write. When any of these checks fails, it pulses an error, changes nothing and returns zero.

On the receive side, each channel has a capture strobe with a byte-valid flag and a data byte. A capture with valid data loads the receive byte, sets the channel's receive-ready flag and pulses a receive event. A capture without valid data loads zero and clears the flag. Reading the receive byte clears the flag. Writing the transmit byte stores it, presents it on the channel's transmit output and pulses a transmit event. The serializer and the interrupt logic sit outside this block and connect to these events and bytes.

Top module: `sio3_regfile`

## Requirements
- R1: After reset, every control, interrupt-mode, transmit, receive, status and timer register reads as zero.
- R2: Channel n (0..2) decodes control at offset 0x10·n, interrupt mode at +0x4, transmit at +0x8, receive at +0x9 and status at +0xC. The timer byte sits at 0x2D. Every other offset gives an error.
- R3: Width flag 1 means two bytes and 0 means one byte. Control takes only two-byte accesses. Interrupt mode, transmit, receive and timer take only one-byte accesses. Status takes either width on channels 0 and 1, and only one byte on channel 2.
- R4: A control write to channel 2 that sets any bit of 0x0C04 is rejected. On channels 0 and 1 the whole 16-bit value is stored.
- R5: An interrupt-mode write that sets any bit of 0xCA on channel 2, or any bit of 0x4A on channels 0 and 1, is rejected and the register keeps its value.
- R6: A write to a receive byte or a status word is an error.
- R7: A legal transmit write stores the byte, shows it on that channel's slice of tx_byte (channel n at bits 8n+7:8n), and pulses that channel's tx_evt for exactly one cycle.
- R8: A capture with valid data stores the byte, sets status bit 4 (value 0x0010) and pulses that channel's rx_evt for one cycle.
- R9: A capture without valid data loads zero into the receive byte, clears status bit 4 and gives no rx_evt.
- R10: Reading the receive byte returns it and clears status bit 4.
- R11: A new capture overwrites an unread byte. A receive read in the same cycle as a valid capture returns the old byte, and the ready flag stays set.
- R12: rsp_valid follows each request by one cycle, with rd_data and err in that same cycle. err is a one-cycle pulse. A faulting access changes no state and returns zero. rd_data is zero for writes.
- R13: The timer byte is written and read back with one-byte accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = two-byte access, 0 = one byte |
| addr | input | 8 | Byte offset |
| wdata | input | 16 | Write data (one-byte writes use bits 7:0) |
| rx_stb | input | 3 | Per-channel capture strobe |
| rx_avail | input | 3 | Per-channel flag: a byte is present at capture |
| rx_byte | input | 24 | Captured bytes, channel n at bits 8n+7:8n |
| rsp_valid | output | 1 | Response cycle for the previous request |
| rd_data | output | 16 | Read data (one-byte reads in bits 7:0) |
| err | output | 1 | Access violation pulse |
| tx_evt | output | 3 | Per-channel transmit event pulse |
| tx_byte | output | 24 | Transmit bytes, channel n at bits 8n+7:8n |
| rx_evt | output | 3 | Per-channel receive event pulse |

## Verification
Two functions can collide in one cycle: a bus read of a receive byte, and a capture on that same channel. The read wants to clear the ready flag and the capture wants to set it. The bench provokes this by raising a valid capture strobe in the same cycle as the read request. It then judges three things: the returned byte must be the one held before the edge, a later status read must still show the ready bit, and a following receive read must return the newly captured byte. A capture without data in the same cycle as a read is also covered by the bench's reference model, which it compares against on every clock.

// File: rtl/sio3_pkg.sv
package sio3_pkg;
  localparam int NUM_CH   = 3;
  localparam int BYTE_W   = 8;
  localparam int CTL_W    = 16;
  localparam int OFF_W    = 8;
  localparam int CH_W     = 2;
  localparam int RDY_BIT  = 4;
  localparam int TIMER_CH = 2;

  localparam logic [3:0] SUB_CTL = 4'h0;
  localparam logic [3:0] SUB_IMR = 4'h4;
  localparam logic [3:0] SUB_TXB = 4'h8;
  localparam logic [3:0] SUB_RXB = 4'h9;
  localparam logic [3:0] SUB_STS = 4'hC;
  localparam logic [3:0] SUB_TIM = 4'hD;

  localparam logic [CTL_W-1:0]  CTL_LOCK_LAST = 16'h0C04;
  localparam logic [BYTE_W-1:0] IMR_LOCK_LAST = 8'hCA;
  localparam logic [BYTE_W-1:0] IMR_LOCK_STD  = 8'h4A;

  typedef enum logic [2:0] {
    RK_NONE, RK_CTL, RK_IMR, RK_TXB, RK_RXB, RK_STS, RK_TIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e       kind;
    logic [CH_W-1:0] ch;
  } reg_sel_t;

  function automatic reg_sel_t decode_off(input logic [OFF_W-1:0] off);
    reg_sel_t s;
    logic [3:0] hi;
    hi     = off[7:4];
    s.ch   = off[CH_W+3:4];
    s.kind = RK_NONE;
    if (32'(hi) < NUM_CH) begin
      case (off[3:0])
        SUB_CTL: s.kind = RK_CTL;
        SUB_IMR: s.kind = RK_IMR;
        SUB_TXB: s.kind = RK_TXB;
        SUB_RXB: s.kind = RK_RXB;
        SUB_STS: s.kind = RK_STS;
        SUB_TIM: if (32'(hi) == TIMER_CH) s.kind = RK_TIM;
        default: s.kind = RK_NONE;
      endcase
    end
    return s;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_lock(input logic [CH_W-1:0] ch);
    return (ch == CH_W'(TIMER_CH)) ? CTL_LOCK_LAST : '0;
  endfunction

  function automatic logic [BYTE_W-1:0] imr_lock(input logic [CH_W-1:0] ch);
    return (ch == CH_W'(TIMER_CH)) ? IMR_LOCK_LAST : IMR_LOCK_STD;
  endfunction

  function automatic logic width_ok(input reg_kind_e k, input logic [CH_W-1:0] ch,
                                    input logic wide);
    case (k)
      RK_NONE: return 1'b0;
      RK_CTL:  return wide;
      RK_STS:  return !wide || (ch != CH_W'(TIMER_CH));
      default: return !wide;
    endcase
  endfunction

  function automatic logic writable(input reg_kind_e k);
    return (k == RK_CTL) || (k == RK_IMR) || (k == RK_TXB) || (k == RK_TIM);
  endfunction

  function automatic logic lock_clash(input reg_kind_e k, input logic [CH_W-1:0] ch,
                                      input logic [CTL_W-1:0] d);
    case (k)
      RK_CTL:  return |(d & ctl_lock(ch));
      RK_IMR:  return |(d[BYTE_W-1:0] & imr_lock(ch));
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CTL_W-1:0] status_word(input logic rdy);
    return CTL_W'(rdy) << RDY_BIT;
  endfunction
endpackage

// File: rtl/sio3_decode.sv
module sio3_decode
  import sio3_pkg::*;
(
  input  logic             req,
  input  logic             we,
  input  logic             wide,
  input  logic [OFF_W-1:0] addr,
  input  logic [CTL_W-1:0] wdata,
  output reg_sel_t         sel,
  output logic             acc_ok,
  output logic             acc_fault
);
  logic addr_miss;
  logic size_bad;
  logic dir_bad;
  logic lock_bad;

  always_comb begin
    sel       = decode_off(addr);
    addr_miss = (sel.kind == RK_NONE);
    size_bad  = !addr_miss && !width_ok(sel.kind, sel.ch, wide);
    dir_bad   = we && !addr_miss && !writable(sel.kind);
    lock_bad  = we && lock_clash(sel.kind, sel.ch, wdata);
    acc_fault = req && (addr_miss || size_bad || dir_bad || lock_bad);
    acc_ok    = req && !acc_fault;
  end
endmodule

// File: rtl/sio3_chan.sv
module sio3_chan
  import sio3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_imr,
  input  logic              wr_txb,
  input  logic              rd_rxb,
  input  logic [CTL_W-1:0]  wdata,
  input  logic              cap_stb,
  input  logic              cap_avail,
  input  logic [BYTE_W-1:0] cap_byte,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [BYTE_W-1:0] imr_q,
  output logic [BYTE_W-1:0] txb_q,
  output logic [BYTE_W-1:0] rxb_q,
  output logic              rdy_q,
  output logic              tx_pulse,
  output logic              rx_pulse
);
  logic cap_take;
  logic cap_empty;

  assign cap_take  = cap_stb && cap_avail;
  assign cap_empty = cap_stb && !cap_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      imr_q    <= '0;
      txb_q    <= '0;
      rxb_q    <= '0;
      rdy_q    <= 1'b0;
      tx_pulse <= 1'b0;
      rx_pulse <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= wdata;
      if (wr_imr) imr_q <= wdata[BYTE_W-1:0];
      if (wr_txb) txb_q <= wdata[BYTE_W-1:0];
      tx_pulse <= wr_txb;
      rx_pulse <= cap_take;
      if (cap_take) begin
        rxb_q <= cap_byte;
        rdy_q <= 1'b1;
      end else if (cap_empty) begin
        rxb_q <= '0;
        rdy_q <= 1'b0;
      end else if (rd_rxb) begin
        rdy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio3_rdmux.sv
module sio3_rdmux
  import sio3_pkg::*;
(
  input  reg_sel_t                       sel,
  input  logic [NUM_CH-1:0][CTL_W-1:0]   ctl_a,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]  imr_a,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]  txb_a,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]  rxb_a,
  input  logic [NUM_CH-1:0]              rdy_a,
  input  logic [BYTE_W-1:0]              tim_q,
  output logic [CTL_W-1:0]               rd_word
);
  always_comb begin
    rd_word = '0;
    case (sel.kind)
      RK_CTL:  rd_word = ctl_a[sel.ch];
      RK_IMR:  rd_word = CTL_W'(imr_a[sel.ch]);
      RK_TXB:  rd_word = CTL_W'(txb_a[sel.ch]);
      RK_RXB:  rd_word = CTL_W'(rxb_a[sel.ch]);
      RK_STS:  rd_word = status_word(rdy_a[sel.ch]);
      RK_TIM:  rd_word = CTL_W'(tim_q);
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/sio3_regfile.sv
module sio3_regfile
  import sio3_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic                     wide,
  input  logic [7:0]               addr,
  input  logic [15:0]              wdata,
  input  logic [2:0]               rx_stb,
  input  logic [2:0]               rx_avail,
  input  logic [23:0]              rx_byte,
  output logic                     rsp_valid,
  output logic [15:0]              rd_data,
  output logic                     err,
  output logic [2:0]               tx_evt,
  output logic [23:0]              tx_byte,
  output logic [2:0]               rx_evt
);
  reg_sel_t                      sel;
  logic                          acc_ok;
  logic                          acc_fault;
  logic                          do_wr;
  logic                          do_rd;
  logic [NUM_CH-1:0][CTL_W-1:0]  ctl_a;
  logic [NUM_CH-1:0][BYTE_W-1:0] imr_a;
  logic [NUM_CH-1:0][BYTE_W-1:0] txb_a;
  logic [NUM_CH-1:0][BYTE_W-1:0] rxb_a;
  logic [NUM_CH-1:0]             rdy_vec;
  logic [BYTE_W-1:0]             tim_q;
  logic [CTL_W-1:0]              rd_word;

  sio3_decode u_dec (
    .req       (req),
    .we        (we),
    .wide      (wide),
    .addr      (addr),
    .wdata     (wdata),
    .sel       (sel),
    .acc_ok    (acc_ok),
    .acc_fault (acc_fault)
  );

  assign do_wr = acc_ok && we;
  assign do_rd = acc_ok && !we;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (sel.ch == CH_W'(g));
    sio3_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (do_wr && hit && sel.kind == RK_CTL),
      .wr_imr    (do_wr && hit && sel.kind == RK_IMR),
      .wr_txb    (do_wr && hit && sel.kind == RK_TXB),
      .rd_rxb    (do_rd && hit && sel.kind == RK_RXB),
      .wdata     (wdata),
      .cap_stb   (rx_stb[g]),
      .cap_avail (rx_avail[g]),
      .cap_byte  (rx_byte[g*BYTE_W +: BYTE_W]),
      .ctl_q     (ctl_a[g]),
      .imr_q     (imr_a[g]),
      .txb_q     (txb_a[g]),
      .rxb_q     (rxb_a[g]),
      .rdy_q     (rdy_vec[g]),
      .tx_pulse  (tx_evt[g]),
      .rx_pulse  (rx_evt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tim_q <= '0;
    else if (do_wr && sel.kind == RK_TIM) tim_q <= wdata[BYTE_W-1:0];
  end

  sio3_rdmux u_mux (
    .sel     (sel),
    .ctl_a   (ctl_a),
    .imr_a   (imr_a),
    .txb_a   (txb_a),
    .rxb_a   (rxb_a),
    .rdy_a   (rdy_vec),
    .tim_q   (tim_q),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      err       <= 1'b0;
      rd_data   <= '0;
    end else begin
      rsp_valid <= req;
      err       <= acc_fault;
      rd_data   <= do_rd ? rd_word : '0;
    end
  end

  assign tx_byte = txb_a;
endmodule

// File: rtl/sio3_regfile_chk.sv
module sio3_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic        wide,
  input logic [7:0]  addr,
  input logic [2:0]  rx_stb,
  input logic [2:0]  rx_avail,
  input logic        rsp_valid,
  input logic [15:0] rd_data,
  input logic        err,
  input logic [2:0]  tx_evt,
  input logic [2:0]  rx_evt,
  input logic [2:0]  rdy_vec
);
  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  p_rsp_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req));
  p_err_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rd_data == 16'h0 && tx_evt == 3'b000 && rsp_valid));
  p_tx_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_evt) |-> ($onehot0(tx_evt) && $past(req && we && !wide && addr[3:0] == 4'h8)));

  for (genvar i = 0; i < 3; i++) begin : g_c
    p_rx_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt[i] |-> $past(rx_stb[i] && rx_avail[i]));
    p_rdy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_vec[i]) |-> $past(rx_stb[i] && rx_avail[i]));
    p_empty_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb[i] && !rx_avail[i]) |=> !rdy_vec[i]);
    p_capture_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb[i] && rx_avail[i]) |=> rdy_vec[i]);
    p_rx_write_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && (addr == 8'(16*i + 9) || addr == 8'(16*i + 12))) |=> err);
  end
endmodule

bind sio3_regfile sio3_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .we        (we),
  .wide      (wide),
  .addr      (addr),
  .rx_stb    (rx_stb),
  .rx_avail  (rx_avail),
  .rsp_valid (rsp_valid),
  .rd_data   (rd_data),
  .err       (err),
  .tx_evt    (tx_evt),
  .rx_evt    (rx_evt),
  .rdy_vec   (rdy_vec)
);

// File: tb/sio3_regfile_bench.sv
module sio3_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [2:0]  rx_stb = '0, rx_avail = '0;
  logic [23:0] rx_byte = '0;
  logic        rsp_valid, err;
  logic [15:0] rd_data;
  logic [2:0]  tx_evt, rx_evt;
  logic [23:0] tx_byte;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sio3_regfile u_sio3_regfile (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .wide(wide), .addr(addr),
    .wdata(wdata), .rx_stb(rx_stb), .rx_avail(rx_avail), .rx_byte(rx_byte),
    .rsp_valid(rsp_valid), .rd_data(rd_data), .err(err), .tx_evt(tx_evt),
    .tx_byte(tx_byte), .rx_evt(rx_evt)
  );

  // behavioural reference model
  logic [15:0] m_ctl [3];
  logic [7:0]  m_imr [3], m_txb [3], m_rxb [3];
  bit          m_rdy [3];
  logic [7:0]  m_tim;
  logic        e_rsp, e_err;
  logic [15:0] e_rd;
  logic [2:0]  e_tx, e_rx;
  int          mch, mlo, kind;
  bit          bad;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_ctl[c] = 0; m_imr[c] = 0; m_txb[c] = 0; m_rxb[c] = 0; m_rdy[c] = 0;
      end
      m_tim = 0; e_rsp = 0; e_err = 0; e_rd = 0; e_tx = 0; e_rx = 0;
    end else begin
      e_rsp = req; e_err = 0; e_rd = 0; e_tx = 0; e_rx = 0;
      if (req) begin
        mch = addr / 16; mlo = addr % 16; kind = 0;
        if (mch < 3) begin
          if (mlo == 0) kind = 1;
          else if (mlo == 4) kind = 2;
          else if (mlo == 8) kind = 3;
          else if (mlo == 9) kind = 4;
          else if (mlo == 12) kind = 5;
          else if (mlo == 13 && mch == 2) kind = 6;
        end
        bad = (kind == 0);
        if (kind == 1 && !wide) bad = 1;
        if ((kind == 2 || kind == 3 || kind == 4 || kind == 6) && wide) bad = 1;
        if (kind == 5 && wide && mch == 2) bad = 1;
        if (we && (kind == 4 || kind == 5)) bad = 1;
        if (we && kind == 1 && mch == 2 && (wdata & 16'h0C04) != 0) bad = 1;
        if (we && kind == 2 && (wdata[7:0] & ((mch == 2) ? 8'hCA : 8'h4A)) != 0) bad = 1;
        if (bad) e_err = 1;
        else if (we) begin
          if (kind == 1) m_ctl[mch] = wdata;
          if (kind == 2) m_imr[mch] = wdata[7:0];
          if (kind == 3) begin m_txb[mch] = wdata[7:0]; e_tx[mch] = 1; end
          if (kind == 6) m_tim = wdata[7:0];
        end else begin
          if (kind == 1) e_rd = m_ctl[mch];
          if (kind == 2) e_rd = {8'h0, m_imr[mch]};
          if (kind == 3) e_rd = {8'h0, m_txb[mch]};
          if (kind == 4) begin e_rd = {8'h0, m_rxb[mch]}; m_rdy[mch] = 0; end
          if (kind == 5) e_rd = m_rdy[mch] ? 16'h0010 : 16'h0000;
          if (kind == 6) e_rd = {8'h0, m_tim};
        end
      end
      for (int c = 0; c < 3; c++) begin
        if (rx_stb[c]) begin
          if (rx_avail[c]) begin
            m_rxb[c] = rx_byte[c*8 +: 8]; m_rdy[c] = 1; e_rx[c] = 1;
          end else begin
            m_rxb[c] = 0; m_rdy[c] = 0;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R12 rsp_valid", 32'(rsp_valid), 32'(e_rsp));
      chk("R12 err", 32'(err), 32'(e_err));
      chk("R2 rd_data", 32'(rd_data), 32'(e_rd));
      chk("R7 tx_evt", 32'(tx_evt), 32'(e_tx));
      chk("R7 tx_byte", 32'(tx_byte), 32'({m_txb[2], m_txb[1], m_txb[0]}));
      chk("R8 rx_evt", 32'(rx_evt), 32'(e_rx));
    end
  end

  logic [15:0] got;
  logic        got_err;
  logic [2:0]  got_tx, got_rx;

  task automatic access(input logic w, input logic wd, input logic [7:0] a,
                        input logic [15:0] d);
    req = 1; we = w; wide = wd; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wide = 0; rx_stb = 0;
    got = rd_data; got_err = err; got_tx = tx_evt; got_rx = rx_evt;
  endtask

  task automatic rd(input logic wd, input logic [7:0] a, input string tag,
                    input logic [15:0] exp);
    access(0, wd, a, 0);
    chk(tag, 32'(got), 32'(exp));
    chk({tag, " no-err"}, 32'(got_err), 0);
  endtask

  task automatic bad_acc(input logic w, input logic wd, input logic [7:0] a,
                         input logic [15:0] d, input string tag);
    access(w, wd, a, d);
    chk(tag, 32'(got_err), 1);
  endtask

  task automatic cap_set(input int ch, input logic av, input logic [7:0] b);
    rx_stb[ch] = 1; rx_avail[ch] = av; rx_byte[ch*8 +: 8] = b;
  endtask

  task automatic capture(input int ch, input logic av, input logic [7:0] b);
    cap_set(ch, av, b);
    @(negedge clk);
    rx_stb = 0;
    got_rx = rx_evt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int c = 0; c < 3; c++) begin
      rd(1, 8'(16*c),     "R1 ctl", 0);
      rd(0, 8'(16*c + 4), "R1 imr", 0);
      rd(0, 8'(16*c + 8), "R1 txb", 0);
      rd(0, 8'(16*c + 9), "R1 rxb", 0);
      rd(0, 8'(16*c + 12),"R1 sts", 0);
    end
    rd(0, 8'h2D, "R1 tim", 0);
    chk("R1 tx_byte", 32'(tx_byte), 0);
    // R4 control locking
    access(1, 1, 8'h00, 16'hFFFF); rd(1, 8'h00, "R4 ctl0 full", 16'hFFFF);
    access(1, 1, 8'h10, 16'h0C04); rd(1, 8'h10, "R4 ctl1 full", 16'h0C04);
    bad_acc(1, 1, 8'h20, 16'h0400, "R4 ctl2 lock");
    rd(1, 8'h20, "R4 ctl2 unchanged", 0);
    access(1, 1, 8'h20, 16'h1230); rd(1, 8'h20, "R4 ctl2 ok", 16'h1230);
    // R5 interrupt-mode locking
    bad_acc(1, 0, 8'h14, 16'h0002, "R5 imr1 lock");
    access(1, 0, 8'h14, 16'h00B5); rd(0, 8'h14, "R5 imr1 ok", 16'h00B5);
    bad_acc(1, 0, 8'h14, 16'h0040, "R5 imr1 lock2");
    rd(0, 8'h14, "R5 imr1 kept", 16'h00B5);
    bad_acc(1, 0, 8'h24, 16'h0080, "R5 imr2 lock");
    access(1, 0, 8'h24, 16'h0035); rd(0, 8'h24, "R5 imr2 ok", 16'h0035);
    access(1, 0, 8'h04, 16'h0080); rd(0, 8'h04, "R5 imr0 bit7 ok", 16'h0080);
    // R3 access width
    bad_acc(0, 0, 8'h00, 0, "R3 ctl narrow");
    bad_acc(1, 0, 8'h10, 16'h0001, "R3 ctl narrow write");
    rd(1, 8'h10, "R3 ctl1 kept", 16'h0C04);
    bad_acc(0, 1, 8'h04, 0, "R3 imr wide");
    bad_acc(0, 1, 8'h08, 0, "R3 txb wide");
    bad_acc(0, 1, 8'h19, 0, "R3 rxb wide");
    rd(1, 8'h0C, "R3 sts0 wide", 0);
    rd(1, 8'h1C, "R3 sts1 wide", 0);
    bad_acc(0, 1, 8'h2C, 0, "R3 sts2 wide");
    bad_acc(0, 1, 8'h2D, 0, "R3 tim wide");
    // R2 decode holes
    bad_acc(0, 0, 8'h01, 0, "R2 hole 01");
    bad_acc(0, 0, 8'h0D, 0, "R2 hole 0D");
    bad_acc(0, 0, 8'h1D, 0, "R2 hole 1D");
    bad_acc(0, 1, 8'h30, 0, "R2 hole 30");
    bad_acc(0, 0, 8'hFF, 0, "R2 hole FF");
    // R6 illegal writes
    bad_acc(1, 0, 8'h09, 16'h0055, "R6 rxb write");
    bad_acc(1, 0, 8'h2C, 16'h0010, "R6 sts write");
    rd(0, 8'h2C, "R6 sts2 unchanged", 0);
    // R13 timer
    access(1, 0, 8'h2D, 16'h009C); rd(0, 8'h2D, "R13 tim", 16'h009C);
    // R7 transmit
    access(1, 0, 8'h18, 16'h005A);
    chk("R7 tx event ch1", 32'(got_tx), 32'h2);
    chk("R7 tx byte ch1", 32'(tx_byte[15:8]), 32'h5A);
    @(negedge clk);
    chk("R7 tx pulse ends", 32'(tx_evt), 0);
    rd(0, 8'h18, "R7 txb readback", 16'h005A);
    // R8 / R10 capture then read
    capture(0, 1, 8'h41);
    chk("R8 rx event ch0", 32'(got_rx), 32'h1);
    rd(0, 8'h0C, "R8 sts ready", 16'h0010);
    rd(0, 8'h09, "R10 rxb read", 16'h0041);
    rd(0, 8'h0C, "R10 ready cleared", 0);
    // R9 capture without data
    capture(2, 1, 8'h77);
    rd(0, 8'h2C, "R9 pre ready", 16'h0010);
    capture(2, 0, 8'hEE);
    chk("R9 no event", 32'(got_rx), 0);
    rd(0, 8'h2C, "R9 ready cleared", 0);
    rd(0, 8'h29, "R9 rxb zero", 0);
    // R11 overwrite and same-cycle read with capture
    capture(1, 1, 8'h11);
    capture(1, 1, 8'h22);
    rd(0, 8'h19, "R11 overwrite", 16'h0022);
    capture(1, 1, 8'h33);
    cap_set(1, 1, 8'h44);
    rd(0, 8'h19, "R11 old byte on collision", 16'h0033);
    rd(0, 8'h1C, "R11 ready kept", 16'h0010);
    rd(0, 8'h19, "R11 new byte", 16'h0044);
    rd(0, 8'h1C, "R11 ready cleared after", 0);
    // read collides with empty capture: model checks per cycle
    capture(0, 1, 8'h5C);
    cap_set(0, 0, 8'h00);
    rd(0, 8'h09, "R11 old byte vs empty capture", 16'h005C);
    rd(0, 8'h09, "R9 rxb zero after empty", 0);
    // R12 back-to-back mixed traffic
    access(1, 0, 8'h08, 16'h0061);
    access(0, 0, 8'h99, 0);
    chk("R12 err after bad", 32'(got_err), 1);
    access(0, 0, 8'h08, 0);
    chk("R12 err single pulse", 32'(got_err), 0);
    chk("R12 data after err", 32'(got), 32'h61);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule